// File: doc/BRIEF.md
# PLL Lock Supervision Sequencer

This block supervises the bring-up of a digital phase-locked loop. It keeps one 32-bit configuration word that chooses the reference source, the reference divide ratio, the lock time-out, a lock bypass, a fast wake-up option, and the loop filter and low-power settings. The last two are not used inside the block. They are passed straight out to the analog loop. The word can be written only while the PLL enable input is low.

Once enabled, the sequencer counts a fixed startup interval in ticks of a 1 kHz timebase. It then waits for the loop's lock indication and finally opens a clock-enable gate for the PLL output. A selectable time-out can stop the wait. When it expires, a sticky time-out status is raised and the output stays gated.

In parallel, a divider turns pulses of the main oscillator into a divided reference level. A multiplexer presents the selected reference source as a single-cycle strobe.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset the configuration word reads 0, and `clkGate`, `locked` and `lockTimeout` are all 0.
- R2: A write with `wrEn` high while `pllEnable` is low stores `wrData` masked to the implemented bits (mask 0x07FF173F). Unimplemented bits read back as 0 on `cfgRdata`.
- R3: A write while `pllEnable` is high is ignored, and `cfgRdata` keeps its value.
- R4: The divide value sits in bits 26:16. `refDiv` toggles after every divide+1 `srcMain` pulses, so its period is 2×(divide+1) main pulses. If the counter is already at or past the divide value when a pulse arrives, it wraps.
- R5: The reference select sits in bits 5:4. It drives `refStrobe` from one of these sources:
  - 0: `srcXtal`.
  - 1: the `srcMain` pulse that makes `refDiv` rise.
  - 2: `srcGen`.
  - 3: treated as 1.
- R6: After `pllEnable` rises, the startup interval lasts START_TICKS `msTick` pulses. With fast wake (bit 3) set to 1, `clkGate` goes high one cycle after the clock edge that samples the last startup tick.
- R7: With fast wake set to 0, `clkGate` is high only once `locked` is high. `locked` rises one cycle after the edge at which the effective lock is sampled after startup.
- R8: With lock bypass (bit 12) set to 1, the effective lock is always asserted, whatever `lockIn` is.
- R9: Lock time (bits 10:8) values 4 to 7 give a time-out of 8 to 11 ticks counted after startup. If no lock is seen by the last tick, `lockTimeout` rises and `clkGate` and `locked` stay 0 until disable. A lock sampled in the same cycle as the last tick wins.
- R10: Lock time values 0 to 3 never time out.
- R11: Dropping `pllEnable` clears `locked`, `clkGate` and `lockTimeout` one cycle later.
- R12: `filterSel` equals bits 1:0 and `lowPower` equals bit 2 of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Stored configuration word |
| pllEnable | input | 1 | PLL enable; blocks writes while high |
| lockIn | input | 1 | Lock indication from the loop |
| msTick | input | 1 | 1 kHz timebase pulse |
| srcXtal | input | 1 | 32 kHz crystal pulse |
| srcMain | input | 1 | Main oscillator pulse |
| srcGen | input | 1 | Generic clock pulse |
| refDiv | output | 1 | Divided main-oscillator level |
| refStrobe | output | 1 | Selected reference strobe |
| clkGate | output | 1 | PLL output clock enable |
| locked | output | 1 | Lock status |
| lockTimeout | output | 1 | Sticky lock time-out status |
| filterSel | output | 2 | Loop filter selection pass-through |
| lowPower | output | 1 | Low-power enable pass-through |

## Verification
The sequencer runs through several startup cases:
- fast wake on and off, which separates gating on startup alone from gating on startup plus lock;
- a reserved, a zero and a 9-tick lock time, which separates never timing out from expiring on the right tick;
- lock bypass with `lockIn` held low, which shows the forced lock;
- a lock that arrives on the very cycle of the final time-out tick, which checks that lock takes priority.

The divider is driven with a main pulse on every cycle and with sparse pulses, which shows that it counts pulses rather than clock cycles. Each reference select value is swept and its strobe matched against its own source, including the reserved code.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int DIV_W = 11;
  localparam logic [31:0] CFG_MASK = 32'h07FF_173F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_RUN,
    ST_TOUT
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntCmd_t;

  typedef struct packed {
    logic [DIV_W-1:0] divVal;
    logic             lockBypass;
    logic [2:0]       lockTime;
    logic [1:0]       refSel;
    logic             fastWake;
    logic             lowPower;
    logic [1:0]       filterSel;
  } cfgFields_t;

  function automatic cfgFields_t unpackCfg(input logic [31:0] w);
    cfgFields_t f;
    f.divVal     = w[26:16];
    f.lockBypass = w[12];
    f.lockTime   = w[10:8];
    f.refSel     = w[5:4];
    f.fastWake   = w[3];
    f.lowPower   = w[2];
    f.filterSel  = w[1:0];
    return f;
  endfunction

  // 0 means no time-out; upper half of the code space maps to 8..11 ticks
  function automatic logic [3:0] timeoutLimit(input logic [2:0] code);
    return code[2] ? (4'd8 + {2'b00, code[1:0]}) : 4'd0;
  endfunction

endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [31:0]      wrData,
  input  logic             pllEnable,
  input  logic             srcXtal,
  input  logic             srcMain,
  input  logic             srcGen,
  input  cntCmd_t          cmd,
  output cfgFields_t       cfg,
  output logic [31:0]      cfgWord,
  output logic [CNT_W-1:0] cnt,
  output logic             refDiv,
  output logic             refStrobe
);

  logic [31:0]      cfgReg;
  logic [DIV_W-1:0] divCnt;
  logic             divWrap;
  logic             divRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (wrEn && !pllEnable) begin
      cfgReg <= wrData & CFG_MASK;
    end
  end

  assign cfgWord = cfgReg;
  assign cfg     = unpackCfg(cfgReg);

  // divider: wraps at the programmed value, or past it after a reprogram
  assign divWrap = srcMain && (divCnt >= cfg.divVal);
  assign divRise = divWrap && !refDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      refDiv <= 1'b0;
    end else if (srcMain) begin
      if (divWrap) begin
        divCnt <= '0;
        refDiv <= ~refDiv;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (cfg.refSel)
      2'd0:    refStrobe = srcXtal;
      2'd2:    refStrobe = srcGen;
      default: refStrobe = divRise;
    endcase
  end

  // shared tick counter for the startup and time-out windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.cntClr) begin
      cnt <= '0;
    end else if (cmd.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pll_seq_ctl.sv
module pll_seq_ctl
  import pll_seq_pkg::*;
#(
  parameter int START_TICKS = 3,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pllEnable,
  input  logic             lockIn,
  input  logic             msTick,
  input  logic             lockBypass,
  input  logic [2:0]       lockTime,
  input  logic             fastWake,
  input  logic [CNT_W-1:0] cnt,
  output cntCmd_t          cmd,
  output logic             clkGate,
  output logic             locked,
  output logic             lockTimeout
);

  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_TICKS - 1);

  seqState_t        state, nxt;
  logic             effLock;
  logic [3:0]       limit;
  logic             toOn;
  logic             startDone;
  logic             toHit;

  assign effLock   = lockBypass | lockIn;
  assign limit     = timeoutLimit(lockTime);
  assign toOn      = (limit != 4'd0);
  assign startDone = msTick && (cnt == START_LAST);
  assign toHit     = toOn && msTick && ((cnt + CNT_W'(1)) == CNT_W'(limit));

  always_comb begin
    nxt = state;
    cmd = '0;
    if (!pllEnable) begin
      nxt        = ST_IDLE;
      cmd.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nxt        = ST_START;
          cmd.cntClr = 1'b1;
        end
        ST_START: begin
          if (startDone) begin
            nxt        = ST_WAIT;
            cmd.cntClr = 1'b1;
          end else begin
            cmd.cntInc = msTick;
          end
        end
        ST_WAIT: begin
          if (effLock) begin
            nxt = ST_RUN;
          end else if (toHit) begin
            nxt = ST_TOUT;
          end else begin
            cmd.cntInc = msTick && toOn;
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      locked      <= 1'b0;
      clkGate     <= 1'b0;
      lockTimeout <= 1'b0;
    end else begin
      state       <= nxt;
      locked      <= (nxt == ST_RUN);
      clkGate     <= (nxt == ST_RUN) || ((nxt == ST_WAIT) && fastWake);
      lockTimeout <= (nxt == ST_TOUT);
    end
  end

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
  import pll_seq_pkg::*;
#(
  parameter int START_TICKS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] cfgRdata,
  input  logic        pllEnable,
  input  logic        lockIn,
  input  logic        msTick,
  input  logic        srcXtal,
  input  logic        srcMain,
  input  logic        srcGen,
  output logic        refDiv,
  output logic        refStrobe,
  output logic        clkGate,
  output logic        locked,
  output logic        lockTimeout,
  output logic [1:0]  filterSel,
  output logic        lowPower
);

  localparam int MAX_COUNT = (START_TICKS > 11) ? START_TICKS : 11;
  localparam int CNT_W     = $clog2(MAX_COUNT + 1);

  cntCmd_t          cmd;
  cfgFields_t       cfg;
  logic [CNT_W-1:0] cnt;

  pll_seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .pllEnable (pllEnable),
    .srcXtal   (srcXtal),
    .srcMain   (srcMain),
    .srcGen    (srcGen),
    .cmd       (cmd),
    .cfg       (cfg),
    .cfgWord   (cfgRdata),
    .cnt       (cnt),
    .refDiv    (refDiv),
    .refStrobe (refStrobe)
  );

  pll_seq_ctl #(.START_TICKS(START_TICKS), .CNT_W(CNT_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .pllEnable   (pllEnable),
    .lockIn      (lockIn),
    .msTick      (msTick),
    .lockBypass  (cfg.lockBypass),
    .lockTime    (cfg.lockTime),
    .fastWake    (cfg.fastWake),
    .cnt         (cnt),
    .cmd         (cmd),
    .clkGate     (clkGate),
    .locked      (locked),
    .lockTimeout (lockTimeout)
  );

  assign filterSel = cfg.filterSel;
  assign lowPower  = cfg.lowPower;

endmodule

// File: rtl/pll_lock_seq_chk.sv
module pll_lock_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        pllEnable,
  input logic [31:0] cfgRdata,
  input logic        clkGate,
  input logic        locked,
  input logic        lockTimeout
);

  // R2
  unimpl_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata & ~32'h07FF_173F) == 32'h0);

  // R3
  write_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pllEnable && wrEn) |=> $stable(cfgRdata));

  // R7
  slow_wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkGate && !cfgRdata[3]) |-> locked);

  // R9
  timeout_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockTimeout |-> (!clkGate && !locked));

  // R11
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pllEnable |=> (!locked && !clkGate && !lockTimeout));

endmodule

bind pll_lock_seq pll_lock_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .pllEnable   (pllEnable),
  .cfgRdata    (cfgRdata),
  .clkGate     (clkGate),
  .locked      (locked),
  .lockTimeout (lockTimeout)
);

// File: tb/tb_pll_lock_seq.sv
`timescale 1ns/1ps
module tb_pll_lock_seq;

  localparam int START = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] cfgRdata;
  logic        pllEnable = 1'b0;
  logic        lockIn = 1'b0;
  logic        msTick = 1'b0;
  logic        srcXtal = 1'b0;
  logic        srcMain = 1'b0;
  logic        srcGen = 1'b0;
  logic        refDiv, refStrobe, clkGate, locked, lockTimeout, lowPower;
  logic [1:0]  filterSel;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit mainFast = 1'b1;
  bit done = 1'b0;

  // reference model state
  int mCfg = 0, mDivCnt = 0, mDivOut = 0, mSt = 0, mCnt = 0;

  pll_lock_seq #(.START_TICKS(START)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    int div, lim;
    if (!rstN) begin
      mCfg = 0; mDivCnt = 0; mDivOut = 0; mSt = 0; mCnt = 0;
    end else begin
      div = (mCfg >> 16) & 32'h7FF;
      lim = (((mCfg >> 8) & 7) >= 4) ? (8 + (((mCfg >> 8) & 7) - 4)) : 0;
      if (srcMain) begin
        if (mDivCnt >= div) begin mDivCnt = 0; mDivOut = 1 - mDivOut; end
        else mDivCnt++;
      end
      if (!pllEnable) begin
        mSt = 0; mCnt = 0;
      end else begin
        case (mSt)
          0: begin mSt = 1; mCnt = 0; end
          1: if (msTick) begin
               mCnt++;
               if (mCnt == START) begin mSt = 2; mCnt = 0; end
             end
          2: if (mCfg[12] || lockIn) mSt = 3;
             else if (lim > 0 && msTick) begin
               mCnt++;
               if (mCnt == lim) mSt = 4;
             end
          default: ;
        endcase
      end
      if (wrEn && !pllEnable) mCfg = wrData & 32'h07FF173F;
    end
    #3;
    if (!done) begin
      int sel, div2;
      bit expStrobe;
      sel  = (mCfg >> 4) & 3;
      div2 = (mCfg >> 16) & 32'h7FF;
      if (sel == 0) expStrobe = srcXtal;
      else if (sel == 2) expStrobe = srcGen;
      else expStrobe = srcMain && (mDivCnt >= div2) && (mDivOut == 0);
      check("R2/R3 config word", cfgRdata, mCfg);
      check("R4 divided level", {31'b0, refDiv}, mDivOut);
      check("R5 reference strobe", {31'b0, refStrobe}, {31'b0, expStrobe});
      check("R6/R7 clock gate", {31'b0, clkGate},
            ((mSt == 3) || (mSt == 2 && mCfg[3])) ? 1 : 0);
      check("R7/R8 locked", {31'b0, locked}, (mSt == 3) ? 1 : 0);
      check("R9 time-out", {31'b0, lockTimeout}, (mSt == 4) ? 1 : 0);
      check("R12 filter", {30'b0, filterSel}, mCfg & 3);
      check("R12 low power", {31'b0, lowPower}, (mCfg >> 2) & 1);
    end
  end

  task automatic step(input bit tk);
    @(posedge clk); #1;
    cyc++;
    wrEn    = 1'b0;
    msTick  = tk;
    srcXtal = (cyc % 5 == 0);
    srcMain = mainFast ? 1'b1 : (cyc % 3 == 0);
    srcGen  = (cyc % 4 == 1);
  endtask

  task automatic wr(input logic [31:0] d);
    step(0);
    wrEn = 1'b1;
    wrData = d;
    step(0);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1);
      repeat (gap) step(0);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int tog, cnt;
    logic prev;
    repeat (3) step(0);
    #1;
    // R1
    check("R1 reset config", cfgRdata, 32'h0);
    check("R1 reset gate", {31'b0, clkGate}, 32'h0);
    check("R1 reset locked", {31'b0, locked}, 32'h0);
    check("R1 reset time-out", {31'b0, lockTimeout}, 32'h0);
    rstN = 1'b1;
    step(0);

    // R2: masking of unimplemented bits
    wr(32'hFFFF_FFFF); #1;
    check("R2 masked write", cfgRdata, 32'h07FF_173F);

    // divide 2, main select, fast wake, low power, filter 2
    wr(32'h0002_001E); #1;
    check("R12 filter pass", {30'b0, filterSel}, 32'd2);
    check("R12 low power pass", {31'b0, lowPower}, 32'd1);

    // R4: 60 main pulses with divide 2 give 20 toggles
    tog = 0; prev = refDiv;
    for (int i = 0; i < 60; i++) begin
      step(0); #1;
      if (refDiv !== prev) tog++;
      prev = refDiv;
    end
    check("R4 toggle count", tog, 20);

    // sparse main pulses
    mainFast = 1'b0;
    repeat (40) step(0);
    mainFast = 1'b1;

    // R6: fast wake gate after startup only
    pllEnable = 1'b1;
    step(0);
    ticks(START - 1, 2); #1;
    check("R6 gate during startup", {31'b0, clkGate}, 32'd0);
    step(1); step(0); #1;
    check("R6 gate after startup", {31'b0, clkGate}, 32'd1);
    check("R7 not yet locked", {31'b0, locked}, 32'd0);

    // R3: write while enabled ignored
    wr(32'h0000_0000); #1;
    check("R3 protected write", cfgRdata, 32'h0002_001E);

    lockIn = 1'b1;
    step(0); step(0); #1;
    check("R7 locked", {31'b0, locked}, 32'd1);

    // R11
    pllEnable = 1'b0;
    step(0); step(0); #1;
    check("R11 locked cleared", {31'b0, locked}, 32'd0);
    check("R11 gate cleared", {31'b0, clkGate}, 32'd0);
    lockIn = 1'b0;

    // R9: 9-tick time-out, slow wake
    wr(32'h0000_0500);
    pllEnable = 1'b1;
    step(0);
    ticks(START, 1);
    ticks(8, 1); #1;
    check("R9 no time-out before limit", {31'b0, lockTimeout}, 32'd0);
    check("R7 slow wake gated", {31'b0, clkGate}, 32'd0);
    ticks(1, 1); #1;
    check("R9 time-out raised", {31'b0, lockTimeout}, 32'd1);
    lockIn = 1'b1;
    step(0); step(0); #1;
    check("R9 late lock ignored", {31'b0, locked}, 32'd0);
    check("R9 gate held", {31'b0, clkGate}, 32'd0);
    pllEnable = 1'b0;
    step(0); step(0); #1;
    check("R11 time-out cleared", {31'b0, lockTimeout}, 32'd0);
    lockIn = 1'b0;

    // R10: reserved code, then zero
    wr(32'h0000_0200);
    pllEnable = 1'b1;
    step(0);
    ticks(START + 20, 1); #1;
    check("R10 reserved no time-out", {31'b0, lockTimeout}, 32'd0);
    pllEnable = 1'b0;
    step(0);
    wr(32'h0000_0000);
    pllEnable = 1'b1;
    step(0);
    ticks(START + 20, 1); #1;
    check("R10 zero no time-out", {31'b0, lockTimeout}, 32'd0);
    lockIn = 1'b1;
    step(0); step(0); #1;
    check("R7 lock after long wait", {31'b0, locked}, 32'd1);
    pllEnable = 1'b0;
    lockIn = 1'b0;
    step(0);

    // R8: bypass with a time-out armed and lockIn low
    wr(32'h0000_1700);
    pllEnable = 1'b1;
    step(0);
    ticks(START, 2); #1;
    check("R8 bypass lock", {31'b0, locked}, 32'd1);
    pllEnable = 1'b0;
    step(0);

    // R9 corner: lock on the final time-out tick wins
    wr(32'h0000_0400);
    pllEnable = 1'b1;
    step(0);
    ticks(START, 1);
    ticks(7, 1);
    step(1);
    lockIn = 1'b1;
    step(0); step(0); #1;
    check("R9 lock wins on last tick", {31'b0, locked}, 32'd1);
    check("R9 no time-out on tie", {31'b0, lockTimeout}, 32'd0);
    pllEnable = 1'b0;
    lockIn = 1'b0;
    step(0);

    // R5: source sweep
    wr(32'h0000_0000);
    for (int i = 0; i < 20; i++) begin
      step(0); #1;
      check("R5 crystal select", {31'b0, refStrobe}, {31'b0, srcXtal});
    end
    wr(32'h0000_0020);
    for (int i = 0; i < 20; i++) begin
      step(0); #1;
      check("R5 generic select", {31'b0, refStrobe}, {31'b0, srcGen});
    end
    wr(32'h0000_0030);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      step(0); #1;
      if (refStrobe) cnt++;
    end
    check("R5 reserved maps to divided main", cnt, 20);

    step(0);
    finishRun();
  end

endmodule